// File: doc/BRIEF.md
# Contrastive Divergence Training Controller

This block sequences one training pass of a restricted Boltzmann machine built as a resistive crossbar. It walks four phases in a fixed order: a forward pass that samples the hidden layer from the training vector, a backward pass that regenerates the visible layer from those hidden samples, a reconstruction pass that samples the hidden layer again from the regenerated visible vector, and a weight update. In each of the first three phases it latches the sampled neuron values that the array presents, and in the update phase it turns those four captured vectors into write patterns for the crossbar, one hidden column per clock.

During the three sampling phases the read word line is asserted, every write word line is low and the bit and source lines are released, which is shown by a low line-drive enable. During the update, the read word line drops, the write word line of the current column rises, and each row gets a bit-line and source-line level: bit line high alone raises that weight, source line high alone lowers it, both low leaves it. A host starts a pass with a start pulse in training mode, watches busy, and gets a one-cycle done pulse when the last column has been written. In inference mode the controller never leaves the forward phase.

Top module: `cd_train_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the controller is in the forward phase with busy and done low, the read word line high, all write word lines low, the line-drive enable low, and bit-line and source-line outputs all zero.
- R2: When the training-mode input is low, a start pulse is ignored: busy stays low and the outputs keep their forward-phase values.
- R3: A start sampled in the forward phase with training mode high begins a pass that lasts HID_W+3 clocks counting the accepting cycle; phases follow forward, backward, reconstruction, update, and after the last update column the controller returns to the forward phase. Busy is high for the HID_W+2 cycles after acceptance.
- R4: The visible and hidden inputs are captured as v and h in the accepting cycle, the visible input as v_bar during the backward cycle, and the hidden input as h_bar during the reconstruction cycle; input values at any other time have no effect on the update patterns.
- R5: Outside the update phase, the read word line is high, all write word lines and the line-drive enable are low, and bit-line and source-line outputs are zero.
- R6: In update cycle j (j from 0 to HID_W-1) the read word line is low, the line-drive enable is high and only write word line bit j is high.
- R7: In update cycle j, bit-line bit i equals v[i] AND h[j] and source-line bit i equals v_bar[i] AND h_bar[j]; neuron 0 occupies bit 0 of every vector.
- R8: Done is high for exactly one cycle, the first cycle back in the forward phase after the last update column, and busy is low in that cycle.
- R9: A start pulse while a pass is in progress is ignored: the pass keeps its length and captured values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request to begin a training pass |
| train_mode | input | 1 | High selects training, low holds inference |
| vis_in | input | VIS_W | Sampled visible-layer neuron outputs from the array |
| hid_in | input | HID_W | Sampled hidden-layer neuron outputs from the array |
| rwl | output | 1 | Read word line enable |
| wwl | output | HID_W | Write word line per hidden column, one-hot in update |
| bl | output | VIS_W | Bit-line level per visible row |
| sl | output | VIS_W | Source-line level per visible row |
| line_en | output | 1 | Bit/source line drive enable; low means released |
| busy | output | 1 | A training pass is in progress |
| done | output | 1 | One-cycle pulse at the end of a pass |

## Verification
The hardest case to reach from the ports is proving that each captured vector comes from exactly its own phase, because the array inputs are sampled in three different cycles and only show up later, mixed into the update patterns. The stimulus therefore changes the visible and hidden inputs every cycle of a pass, presenting the wanted vector only in its capture cycle and bitwise-inverted values everywhere else, so a capture in the wrong cycle shows as a wrong bit-line or source-line pattern. Start is also held high through the pass to show it cannot restart or stretch it.

// File: rtl/cd_pkg.sv
// Shared types for the contrastive divergence training controller.
// Assumes: phase encoding is internal only; no neighbour decodes it.
package cd_pkg;
    typedef enum logic [1:0] {
        PH_FWD   = 2'd0,
        PH_BACK  = 2'd1,
        PH_RECON = 2'd2,
        PH_UPD   = 2'd3
    } phase_t;
endpackage

// File: rtl/cd_seq.sv
// Phase sequencer: steps forward -> backward -> reconstruction -> update
// and walks the hidden-column counter through the update phase.
// Assumes: start is only honoured in the forward phase with train_mode high.
module cd_seq
    import cd_pkg::*;
#(
    parameter int HID_W = 2,
    parameter int COL_W = (HID_W > 1) ? $clog2(HID_W) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             train_mode,
    output phase_t           phase,
    output logic [COL_W-1:0] col,
    output logic             accept,
    output logic             done
);
    localparam logic [COL_W-1:0] LAST_COL = COL_W'(HID_W - 1);

    logic last_col;

    // Purpose: flag the final column of the update walk.
    always_comb begin
        last_col = (col == LAST_COL);
        accept   = (phase == PH_FWD) && start && train_mode;
    end

    // Purpose: phase register, column counter and end-of-pass pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_FWD;
            col   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (phase)
                PH_FWD:   if (accept) phase <= PH_BACK;
                PH_BACK:  phase <= PH_RECON;
                PH_RECON: begin
                    phase <= PH_UPD;
                    col   <= '0;
                end
                PH_UPD: begin
                    if (last_col) begin
                        phase <= PH_FWD;
                        col   <= '0;
                        done  <= 1'b1;
                    end else begin
                        col <= col + 1'b1;
                    end
                end
                default: phase <= PH_FWD;
            endcase
        end
    end

    AST_TEST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FWD && !train_mode) |=> (phase == PH_FWD)); // R2
    AST_BACK_TO_RECON: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_BACK) |=> (phase == PH_RECON)); // R3
    AST_COL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_UPD && col != LAST_COL) |=> (phase == PH_UPD && col == $past(col) + 1'b1)); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
endmodule

// File: rtl/cd_capture.sv
// Sample registers: latch v and h on acceptance, v_bar in the backward
// phase and h_bar in the reconstruction phase. Bit 0 is neuron 0.
// Assumes: array outputs are already settled when sampled.
module cd_capture
    import cd_pkg::*;
#(
    parameter int VIS_W = 4,
    parameter int HID_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  phase_t           phase,
    input  logic             accept,
    input  logic [VIS_W-1:0] vis_in,
    input  logic [HID_W-1:0] hid_in,
    output logic [VIS_W-1:0] v_q,
    output logic [HID_W-1:0] h_q,
    output logic [VIS_W-1:0] vb_q,
    output logic [HID_W-1:0] hb_q
);
    // Purpose: load each register only in its own capture cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q  <= '0;
            h_q  <= '0;
            vb_q <= '0;
            hb_q <= '0;
        end else begin
            if (accept) begin
                v_q <= vis_in;
                h_q <= hid_in;
            end
            if (phase == PH_BACK)  vb_q <= vis_in;
            if (phase == PH_RECON) hb_q <= hid_in;
        end
    end

    AST_HOLD_IN_UPD: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_UPD) |=> ($stable(v_q) && $stable(h_q) && $stable(vb_q) && $stable(hb_q))); // R4
endmodule

// File: rtl/cd_line_drv.sv
// Line decoder: word-line enables and per-row bit/source-line levels.
// Assumes: all inputs come straight from flops, so outputs carry no
// combinational path from the block's inputs.
module cd_line_drv
    import cd_pkg::*;
#(
    parameter int VIS_W = 4,
    parameter int HID_W = 2,
    parameter int COL_W = 1
) (
    input  phase_t           phase,
    input  logic [COL_W-1:0] col,
    input  logic [VIS_W-1:0] v_q,
    input  logic [HID_W-1:0] h_q,
    input  logic [VIS_W-1:0] vb_q,
    input  logic [HID_W-1:0] hb_q,
    output logic             rwl,
    output logic [HID_W-1:0] wwl,
    output logic [VIS_W-1:0] bl,
    output logic [VIS_W-1:0] sl,
    output logic             line_en
);
    logic writing;
    logic h_sel;
    logic hb_sel;

    // Purpose: select the current column's hidden bits and phase enables.
    always_comb begin
        writing = (phase == PH_UPD);
        h_sel   = h_q[col];
        hb_sel  = hb_q[col];
        rwl     = !writing;
        line_en = writing;
    end

    // One write word line per hidden column.
    for (genvar c = 0; c < HID_W; c++) begin : g_wwl
        assign wwl[c] = writing && (col == COL_W'(c));
    end

    // One bit-line / source-line pair per visible row.
    for (genvar r = 0; r < VIS_W; r++) begin : g_row
        assign bl[r] = writing && v_q[r]  && h_sel;
        assign sl[r] = writing && vb_q[r] && hb_sel;
    end
endmodule

// File: rtl/cd_train_ctrl.sv
// Top: contrastive divergence training controller for a VIS_W x HID_W
// crossbar. One pass takes HID_W+3 clocks; test mode stays in forward.
// Assumes: host waits for done (or busy low) before the next start.
module cd_train_ctrl
    import cd_pkg::*;
#(
    parameter int VIS_W = 4,
    parameter int HID_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             train_mode,
    input  logic [VIS_W-1:0] vis_in,
    input  logic [HID_W-1:0] hid_in,
    output logic             rwl,
    output logic [HID_W-1:0] wwl,
    output logic [VIS_W-1:0] bl,
    output logic [VIS_W-1:0] sl,
    output logic             line_en,
    output logic             busy,
    output logic             done
);
    localparam int COL_W = (HID_W > 1) ? $clog2(HID_W) : 1;

    phase_t           phase;
    logic [COL_W-1:0] col;
    logic             accept;
    logic [VIS_W-1:0] v_q;
    logic [HID_W-1:0] h_q;
    logic [VIS_W-1:0] vb_q;
    logic [HID_W-1:0] hb_q;

    cd_seq #(.HID_W(HID_W), .COL_W(COL_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .train_mode(train_mode),
        .phase(phase), .col(col), .accept(accept), .done(done)
    );

    cd_capture #(.VIS_W(VIS_W), .HID_W(HID_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .phase(phase), .accept(accept),
        .vis_in(vis_in), .hid_in(hid_in),
        .v_q(v_q), .h_q(h_q), .vb_q(vb_q), .hb_q(hb_q)
    );

    cd_line_drv #(.VIS_W(VIS_W), .HID_W(HID_W), .COL_W(COL_W)) u_drv (
        .phase(phase), .col(col), .v_q(v_q), .h_q(h_q), .vb_q(vb_q), .hb_q(hb_q),
        .rwl(rwl), .wwl(wwl), .bl(bl), .sl(sl), .line_en(line_en)
    );

    // Purpose: host-visible pass indicator.
    always_comb busy = (phase != PH_FWD);

    AST_WWL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wwl)); // R6
    AST_READ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        rwl |-> (wwl == '0 && !line_en && bl == '0 && sl == '0)); // R5
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R8
endmodule

// File: tb/cd_train_ctrl_tb.sv
module cd_train_ctrl_tb;
    localparam int VIS_W = 4;
    localparam int HID_W = 2;

    typedef struct packed {
        logic             rwl;
        logic [HID_W-1:0] wwl;
        logic [VIS_W-1:0] bl;
        logic [VIS_W-1:0] sl;
        logic             line_en;
        logic             busy;
        logic             done;
    } obs_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             train_mode = 1'b0;
    logic [VIS_W-1:0] vis_in = '0;
    logic [HID_W-1:0] hid_in = '0;
    logic             rwl, line_en, busy, done;
    logic [HID_W-1:0] wwl;
    logic [VIS_W-1:0] bl, sl;

    int n_checks = 0;
    int n_fail   = 0;
    bit stim_done = 1'b0;

    obs_t  exp_q[$];
    string tag_q[$];

    always #2 clk = ~clk;

    cd_train_ctrl #(.VIS_W(VIS_W), .HID_W(HID_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .train_mode(train_mode),
        .vis_in(vis_in), .hid_in(hid_in), .rwl(rwl), .wwl(wwl), .bl(bl),
        .sl(sl), .line_en(line_en), .busy(busy), .done(done)
    );

    function automatic obs_t idle_obs(input logic d);
        obs_t o;
        o = '0;
        o.rwl  = 1'b1;
        o.done = d;
        return o;
    endfunction

    function automatic obs_t read_busy_obs();
        obs_t o;
        o = idle_obs(1'b0);
        o.busy = 1'b1;
        return o;
    endfunction

    function automatic obs_t upd_obs(input int j, input logic [VIS_W-1:0] v,
                                     input logic [HID_W-1:0] h, input logic [VIS_W-1:0] vb,
                                     input logic [HID_W-1:0] hb);
        obs_t o;
        o = '0;
        o.wwl     = HID_W'(1) << j;
        o.bl      = v  & {VIS_W{h[j]}};
        o.sl      = vb & {VIS_W{hb[j]}};
        o.line_en = 1'b1;
        o.busy    = 1'b1;
        return o;
    endfunction

    task automatic compare(input obs_t e, input string tag);
        obs_t a;
        a = '{rwl, wwl, bl, sl, line_en, busy, done};
        n_checks++;
        if (a !== e) begin
            n_fail++;
            $display("FAIL %s: actual rwl=%b wwl=%b bl=%b sl=%b en=%b busy=%b done=%b expected rwl=%b wwl=%b bl=%b sl=%b en=%b busy=%b done=%b",
                     tag, a.rwl, a.wwl, a.bl, a.sl, a.line_en, a.busy, a.done,
                     e.rwl, e.wwl, e.bl, e.sl, e.line_en, e.busy, e.done);
        end
    endtask

    // Driver step: set inputs at the falling edge, expect the state after the next rise.
    task automatic step(input logic s, input logic m, input logic [VIS_W-1:0] vi,
                        input logic [HID_W-1:0] hi, input obs_t e, input string tag);
        @(negedge clk);
        start = s; train_mode = m; vis_in = vi; hid_in = hi;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // One training pass; wrong-phase inputs are inverted values (R4) and start stays high (R9).
    task automatic train_pass(input logic [VIS_W-1:0] v, input logic [HID_W-1:0] h,
                              input logic [VIS_W-1:0] vb, input logic [HID_W-1:0] hb);
        step(1'b1, 1'b1, v, h, read_busy_obs(), "R3 backward phase busy, R5 lines released");
        step(1'b1, 1'b1, vb, ~h, read_busy_obs(), "R9 start ignored in reconstruction, R5");
        step(1'b0, 1'b1, ~vb, hb, upd_obs(0, v, h, vb, hb), "R7 column 0 patterns, R6 wwl[0]");
        for (int j = 1; j < HID_W; j++)
            step(1'b1, 1'b1, ~v, ~hb, upd_obs(j, v, h, vb, hb), "R7 later column patterns, R4 capture, R6");
        step(1'b0, 1'b1, ~v, ~h, idle_obs(1'b1), "R8 done pulse, R3 back to forward");
        step(1'b0, 1'b1, '0, '0, idle_obs(1'b0), "R8 done lasts one cycle");
    endtask

    // Monitor: compare one expected item just after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) compare(exp_q.pop_front(), tag_q.pop_front());
        end
    end

    // Watchdog.
    initial begin
        #(200000 * 4);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual run still going, expected end of stimulus");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        compare(idle_obs(1'b0), "R1 state during reset");
        rst_n = 1'b1;
        @(posedge clk); #1;
        compare(idle_obs(1'b0), "R1 state after reset release");

        // Test mode: start ignored.
        for (int k = 0; k < 3; k++)
            step(1'b1, 1'b0, 4'hF, 2'h3, idle_obs(1'b0), "R2 inference mode holds forward");

        // Worked example: v=0101 h=01 v_bar=0100 h_bar=10.
        train_pass(4'b0101, 2'b01, 4'b0100, 2'b10);
        // Every weight raised on column 0 and 1, none lowered.
        train_pass(4'b1111, 2'b11, 4'b0000, 2'b00);
        // Hidden all zero, reconstruction nonzero: only decreases.
        train_pass(4'b1001, 2'b00, 4'b0110, 2'b11);
        // Mixed increase and decrease on the same column.
        train_pass(4'b1010, 2'b10, 4'b0111, 2'b10);

        // Inference again after training.
        step(1'b1, 1'b0, 4'h5, 2'h2, idle_obs(1'b0), "R2 inference mode after training");
        step(1'b0, 1'b0, 4'h0, 2'h0, idle_obs(1'b0), "R2 inference mode idle");

        @(negedge clk);
        @(negedge clk);
        stim_done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule